// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps the per-vector message table and the pending bits of a message-signalled interrupt function inside one 4 KiB register page. Software reaches the page through a 32-bit word port. A separate control write sets the function enable and the function-wide mask. The device raises interrupt requests by vector number and marks vectors as in use or no longer in use. The block turns each request into one memory-write message, carrying a 64-bit address and 32-bit data, on a valid/ready output.

A request that hits a masked vector is stored as a pending bit. The stored request is delivered later, when that vector becomes unmasked. Unmasking can happen in two ways. A table write can clear the vector's own mask, and the block then re-examines that vector. A control write can lift the function mask while the function stays enabled, and the block then re-examines every configured vector from the lowest index upward. Only one message is held at a time. While it waits for the receiver, new requests and re-examination steps stall.

Top module: `msixc_top`

## Requirements
- R1: After reset, the enable and function-mask bits are 0. All table words read 0, except the control word of each configured vector, which reads 1. The pending bits read 0 and every use count is 0.
- R2: Vector n occupies the 16 bytes starting at byte offset 16·n. Word 0 holds the address low half, word 1 the address high half, word 2 the data, and word 3 the control word, whose bit 0 masks the vector. A read returns its data on `regRdData` one cycle after `regRdEn`. Words beyond the configured vectors read 0 and ignore writes.
- R3: Only accesses with `regSize`=2 (32 bits) take effect. A write with size 0 (byte) or 1 (halfword) changes nothing, and a read of those sizes returns 0.
- R4: The word at byte offset 0x800 holds the pending bits, with bit n belonging to vector n. Writes to that word are ignored.
- R5: `cfgFlags` bit 15 is the enable bit, bit 14 is the function-mask bit, and bits 10:0 read NUM_VEC−1.
- R6: A request is dropped, with no message and no pending bit, when its vector is at or above NUM_VEC or its use count is 0.
- R7: A vector is masked when the function-mask bit or its own mask bit is set. An accepted request to a masked vector in use sets its pending bit and sends nothing.
- R8: An accepted request to an unmasked vector in use raises `msgValid` in the next cycle. The message address is {high word, low word} and the data is the entry's data word. Address and data stay stable until `msgReady`.
- R9: After a 32-bit table write, the block re-examines the written vector. If that vector is unmasked and pending, the block clears the pending bit and sends its message.
- R10: A control write with enable=1 pulses `intxDeassert` in the next cycle. If that write also leaves the function unmasked, every configured vector is re-examined as in R9, lowest index first.
- R11: `useInc` raises a vector's use count and `useDec` lowers it. Lowering a count of 0 is ignored. When a count reaches 0, the vector's pending bit is cleared.
- R12: At most one message is held. While it is not accepted, `reqReady` is low. During a re-examination sweep, a request is accepted only when it targets the vector under examination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| regWrEn | input | 1 | Page write strobe |
| regRdEn | input | 1 | Page read strobe |
| regAddr | input | 10 | Word address in the page (byte offset bits 11:2) |
| regSize | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, one cycle after the read strobe |
| cfgWrEn | input | 1 | Control-byte write strobe |
| cfgEnableIn | input | 1 | New enable bit |
| cfgMaskAllIn | input | 1 | New function-mask bit |
| cfgFlags | output | 16 | Flags word: enable, function mask, table size |
| useInc | input | 1 | Mark vector used |
| useDec | input | 1 | Mark vector unused |
| useVec | input | 5 | Vector for use operations |
| reqValid | input | 1 | Device interrupt request |
| reqVec | input | 5 | Requested vector |
| reqReady | output | 1 | Request accepted this cycle |
| msgValid | output | 1 | Message held for the receiver |
| msgReady | input | 1 | Receiver takes the message |
| msgAddr | output | 64 | Message address |
| msgData | output | 32 | Message data |
| intxDeassert | output | 1 | Pulse that drops legacy INTx |

## Verification
A request accepted at clock edge t shows as `msgValid` in the cycle after t, or as a pending bit that a read started after t returns. A table write at edge t is re-examined at edge t+1, so any replayed message is visible in the cycle after t+1. A sweep spends one cycle per configured vector, plus the cycles spent waiting on the message slot. The bench drives every stimulus on the falling clock edge and records handshakes just after it. It then waits several idle cycles past the latest due cycle before it compares message counts, message order, pending words or `intxDeassert`.

// File: rtl/msixc_pkg.sv
package msixc_pkg;
  localparam int VEC_W = 5;
  localparam int MAX_VEC = 32;
  localparam logic [9:0] PBA_WORD = 10'h200;

  typedef struct packed {
    logic setPend;
    logic clrPend;
    logic [VEC_W-1:0] vec;
  } pendStrobe_t;
endpackage

// File: rtl/msixc_datapath.sv
module msixc_datapath
  import msixc_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int USE_W = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWrEn,
  input  logic regRdEn,
  input  logic [11:2] regAddr,
  input  logic [1:0] regSize,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic cfgWrEn,
  input  logic cfgEnableIn,
  input  logic cfgMaskAllIn,
  output logic [15:0] cfgFlags,
  input  logic useInc,
  input  logic useDec,
  input  logic [VEC_W-1:0] useVec,
  input  pendStrobe_t strobe,
  input  logic [VEC_W-1:0] selVec,
  output logic [63:0] selAddr,
  output logic [31:0] selData,
  output logic [NUM_VEC-1:0] vecMasked,
  output logic [NUM_VEC-1:0] vecPending,
  output logic [NUM_VEC-1:0] vecUsed,
  output logic tblWrHit,
  output logic [VEC_W-1:0] tblWrVec,
  output logic sweepReq,
  output logic enableWr
);
  localparam logic [USE_W-1:0] USE_MAX = '1;

  logic [31:0] tbl [NUM_VEC][4];
  logic [USE_W-1:0] useCnt [NUM_VEC];
  logic [NUM_VEC-1:0] pend, pendNext;
  logic fnEnable, fnMaskAll;
  logic isWord, tblHit, pbaHit;
  logic [7:0] rowSel;
  logic [1:0] wordSel;
  logic [31:0] rdNext;

  assign isWord   = regSize == 2'd2;
  assign rowSel   = regAddr[11:4];
  assign wordSel  = regAddr[3:2];
  assign tblHit   = rowSel < 8'(NUM_VEC);
  assign pbaHit   = regAddr == PBA_WORD;
  assign tblWrHit = regWrEn && isWord && tblHit;
  assign tblWrVec = rowSel[VEC_W-1:0];
  assign enableWr = cfgWrEn && cfgEnableIn;
  assign sweepReq = cfgWrEn && cfgEnableIn && !cfgMaskAllIn;
  assign cfgFlags = {fnEnable, fnMaskAll, 3'b000, 11'(NUM_VEC - 1)};
  assign vecPending = pend;

  always_comb begin
    selAddr = '0;
    selData = '0;
    rdNext  = (isWord && pbaHit) ? 32'(pend) : 32'h0;
    for (int v = 0; v < NUM_VEC; v++) begin
      vecMasked[v] = fnMaskAll | tbl[v][3][0];
      vecUsed[v]   = useCnt[v] != '0;
      if (selVec == VEC_W'(v)) begin
        selAddr = {tbl[v][1], tbl[v][0]};
        selData = tbl[v][2];
      end
      for (int w = 0; w < 4; w++)
        if (isWord && tblHit && tblWrVec == VEC_W'(v) && wordSel == 2'(w))
          rdNext = tbl[v][w];
      pendNext[v] = pend[v];
      if (strobe.setPend && strobe.vec == VEC_W'(v)) pendNext[v] = 1'b1;
      if (strobe.clrPend && strobe.vec == VEC_W'(v)) pendNext[v] = 1'b0;
      if (useDec && !useInc && useVec == VEC_W'(v) && useCnt[v] == USE_W'(1))
        pendNext[v] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fnEnable  <= 1'b0;
      fnMaskAll <= 1'b0;
      pend      <= '0;
      regRdData <= '0;
      for (int v = 0; v < NUM_VEC; v++) begin
        useCnt[v] <= '0;
        for (int w = 0; w < 4; w++) tbl[v][w] <= (w == 3) ? 32'h1 : 32'h0;
      end
    end else begin
      if (cfgWrEn) begin
        fnEnable  <= cfgEnableIn;
        fnMaskAll <= cfgMaskAllIn;
      end
      pend <= pendNext;
      if (regRdEn) regRdData <= rdNext;
      for (int v = 0; v < NUM_VEC; v++) begin
        for (int w = 0; w < 4; w++)
          if (tblWrHit && tblWrVec == VEC_W'(v) && wordSel == 2'(w))
            tbl[v][w] <= regWrData;
        if (useVec == VEC_W'(v)) begin
          if (useInc && !useDec && useCnt[v] != USE_MAX)
            useCnt[v] <= useCnt[v] + 1'b1;
          else if (useDec && !useInc && useCnt[v] != '0)
            useCnt[v] <= useCnt[v] - 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_VEC; g++) begin : gChk
    assert_rise_used_R6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pend[g]) |-> $past(useCnt[g] != '0));
    assert_rise_masked_R7: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pend[g]) |-> $past(vecMasked[g]));
    assert_idle_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
      (useCnt[g] == '0) |-> !pend[g]);
  end
endmodule

// File: rtl/msixc_control.sv
module msixc_control
  import msixc_pkg::*;
#(
  parameter int NUM_VEC = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic [VEC_W-1:0] reqVec,
  output logic reqReady,
  input  logic msgReady,
  output logic msgValid,
  output logic [63:0] msgAddr,
  output logic [31:0] msgData,
  output logic intxDeassert,
  input  logic [NUM_VEC-1:0] vecMasked,
  input  logic [NUM_VEC-1:0] vecPending,
  input  logic [NUM_VEC-1:0] vecUsed,
  input  logic [63:0] selAddr,
  input  logic [31:0] selData,
  input  logic tblWrHit,
  input  logic [VEC_W-1:0] tblWrVec,
  input  logic sweepReq,
  input  logic enableWr,
  output logic [VEC_W-1:0] selVec,
  output pendStrobe_t strobe
);
  logic [NUM_VEC-1:0] recheck, recheckNext;
  logic [VEC_W-1:0] lowIdx;
  logic lowAny, slotFree, reqLive, reqMasked, reqTake;
  logic stepGo, stepFire, launch;

  always_comb begin
    lowAny = 1'b0;
    lowIdx = '0;
    reqLive = 1'b0;
    reqMasked = 1'b0;
    stepFire = 1'b0;
    for (int v = NUM_VEC - 1; v >= 0; v--)
      if (recheck[v]) begin
        lowAny = 1'b1;
        lowIdx = VEC_W'(v);
      end
    for (int v = 0; v < NUM_VEC; v++) begin
      if (reqVec == VEC_W'(v)) begin
        reqLive   = vecUsed[v];
        reqMasked = vecMasked[v];
      end
      if (lowIdx == VEC_W'(v)) stepFire = !vecMasked[v] && vecPending[v];
    end
  end

  assign slotFree = !msgValid || msgReady;
  assign reqReady = slotFree && (!lowAny || reqVec == lowIdx);
  assign reqTake  = reqValid && reqReady && reqLive;
  assign stepGo   = slotFree && lowAny && !reqTake;
  assign launch   = (reqTake && !reqMasked) || (stepGo && stepFire);
  assign selVec   = reqTake ? reqVec : lowIdx;

  always_comb begin
    strobe.setPend = reqTake && reqMasked;
    strobe.clrPend = launch;
    strobe.vec     = selVec;
    recheckNext    = recheck;
    if (lowAny && (stepGo || reqTake)) recheckNext[lowIdx] = 1'b0;
    if (sweepReq) recheckNext = '1;
    if (tblWrHit) recheckNext[tblWrVec] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recheck      <= '0;
      msgValid     <= 1'b0;
      msgAddr      <= '0;
      msgData      <= '0;
      intxDeassert <= 1'b0;
    end else begin
      recheck      <= recheckNext;
      intxDeassert <= enableWr;
      if (launch) begin
        msgValid <= 1'b1;
        msgAddr  <= selAddr;
        msgData  <= selData;
      end else if (msgReady) begin
        msgValid <= 1'b0;
      end
    end
  end

  assert_msg_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgAddr) && $stable(msgData)));
  assert_intx_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    enableWr |=> intxDeassert);
  assert_single_msg_R12: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |-> !reqReady);
endmodule

// File: rtl/msixc_top.sv
module msixc_top
  import msixc_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int USE_W = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWrEn,
  input  logic regRdEn,
  input  logic [11:2] regAddr,
  input  logic [1:0] regSize,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic cfgWrEn,
  input  logic cfgEnableIn,
  input  logic cfgMaskAllIn,
  output logic [15:0] cfgFlags,
  input  logic useInc,
  input  logic useDec,
  input  logic [4:0] useVec,
  input  logic reqValid,
  input  logic [4:0] reqVec,
  output logic reqReady,
  output logic msgValid,
  input  logic msgReady,
  output logic [63:0] msgAddr,
  output logic [31:0] msgData,
  output logic intxDeassert
);
  pendStrobe_t strobe;
  logic [VEC_W-1:0] selVec, tblWrVec;
  logic [63:0] selAddr;
  logic [31:0] selData;
  logic [NUM_VEC-1:0] vecMasked, vecPending, vecUsed;
  logic tblWrHit, sweepReq, enableWr;

  msixc_datapath #(.NUM_VEC(NUM_VEC), .USE_W(USE_W)) uDatapath (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regSize(regSize), .regWrData(regWrData),
    .regRdData(regRdData), .cfgWrEn(cfgWrEn), .cfgEnableIn(cfgEnableIn),
    .cfgMaskAllIn(cfgMaskAllIn), .cfgFlags(cfgFlags), .useInc(useInc),
    .useDec(useDec), .useVec(useVec), .strobe(strobe), .selVec(selVec),
    .selAddr(selAddr), .selData(selData), .vecMasked(vecMasked),
    .vecPending(vecPending), .vecUsed(vecUsed), .tblWrHit(tblWrHit),
    .tblWrVec(tblWrVec), .sweepReq(sweepReq), .enableWr(enableWr)
  );

  msixc_control #(.NUM_VEC(NUM_VEC)) uControl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVec(reqVec),
    .reqReady(reqReady), .msgReady(msgReady), .msgValid(msgValid),
    .msgAddr(msgAddr), .msgData(msgData), .intxDeassert(intxDeassert),
    .vecMasked(vecMasked), .vecPending(vecPending), .vecUsed(vecUsed),
    .selAddr(selAddr), .selData(selData), .tblWrHit(tblWrHit),
    .tblWrVec(tblWrVec), .sweepReq(sweepReq), .enableWr(enableWr),
    .selVec(selVec), .strobe(strobe)
  );
endmodule

// File: tb/msixc_top_test.sv
`timescale 1ns/1ps
module msixc_top_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 0, regRdEn = 0;
  logic [11:2] regAddr = '0;
  logic [1:0] regSize = 2'd2;
  logic [31:0] regWrData = '0, regRdData;
  logic cfgWrEn = 0, cfgEnableIn = 0, cfgMaskAllIn = 0;
  logic [15:0] cfgFlags;
  logic useInc = 0, useDec = 0;
  logic [4:0] useVec = '0;
  logic reqValid = 0;
  logic [4:0] reqVec = '0;
  logic reqReady, msgValid, intxDeassert;
  logic msgReady = 1'b1;
  logic [63:0] msgAddr;
  logic [31:0] msgData;

  int testCnt = 0, failCnt = 0, msgCnt = 0;
  logic [63:0] logAddr [16];
  logic [31:0] logData [16];
  logic [31:0] rd;

  always #2 clk = ~clk;

  msixc_top uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regSize(regSize), .regWrData(regWrData),
    .regRdData(regRdData), .cfgWrEn(cfgWrEn), .cfgEnableIn(cfgEnableIn),
    .cfgMaskAllIn(cfgMaskAllIn), .cfgFlags(cfgFlags), .useInc(useInc),
    .useDec(useDec), .useVec(useVec), .reqValid(reqValid), .reqVec(reqVec),
    .reqReady(reqReady), .msgValid(msgValid), .msgReady(msgReady),
    .msgAddr(msgAddr), .msgData(msgData), .intxDeassert(intxDeassert)
  );

  always @(negedge clk) begin
    #1;
    if (rstN && msgValid && msgReady) begin
      if (msgCnt < 16) begin
        logAddr[msgCnt] = msgAddr;
        logData[msgCnt] = msgData;
      end
      msgCnt++;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWr(input logic [11:0] off, input logic [31:0] d, input logic [1:0] sz);
    @(negedge clk);
    regWrEn = 1; regAddr = off[11:2]; regSize = sz; regWrData = d;
    @(negedge clk);
    regWrEn = 0; regSize = 2'd2;
  endtask

  task automatic regRd(input logic [11:0] off, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1; regAddr = off[11:2]; regSize = sz;
    @(negedge clk);
    regRdEn = 0; regSize = 2'd2;
    d = regRdData;
  endtask

  task automatic cfgWr(input logic en, input logic ma);
    @(negedge clk);
    cfgWrEn = 1; cfgEnableIn = en; cfgMaskAllIn = ma;
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic useOp(input logic inc, input logic [4:0] v);
    @(negedge clk);
    useInc = inc; useDec = !inc; useVec = v;
    @(negedge clk);
    useInc = 0; useDec = 0;
  endtask

  task automatic request(input logic [4:0] v);
    @(negedge clk);
    reqValid = 1; reqVec = v;
    #1;
    while (!reqReady) begin @(negedge clk); #1; end
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic testReset();
    chk("R5 flags after reset", 64'(cfgFlags), 64'h0007);
    chk("R1 no message after reset", 64'(msgValid), 64'h0);
    regRd(12'h03C, 2'd2, rd); chk("R1 vector3 control reset", 64'(rd), 64'h1);
    regRd(12'h000, 2'd2, rd); chk("R1 vector0 address reset", 64'(rd), 64'h0);
    regRd(12'h800, 2'd2, rd); chk("R1 pending reset", 64'(rd), 64'h0);
  endtask

  task automatic testTable();
    regWr(12'h020, 32'hFEE0_1000, 2'd2);
    regWr(12'h024, 32'h0000_0001, 2'd2);
    regWr(12'h028, 32'h0000_4022, 2'd2);
    regRd(12'h028, 2'd2, rd); chk("R2 data word readback", 64'(rd), 64'h4022);
    regRd(12'h024, 2'd2, rd); chk("R2 high word readback", 64'(rd), 64'h1);
    regRd(12'h02C, 2'd2, rd); chk("R2 control word still masked", 64'(rd), 64'h1);
    regWr(12'h080, 32'hDEAD_BEEF, 2'd2);
    regRd(12'h080, 2'd2, rd); chk("R2 beyond table reads zero", 64'(rd), 64'h0);
  endtask

  task automatic testWidth();
    regWr(12'h028, 32'h0000_0055, 2'd0);
    regRd(12'h028, 2'd2, rd); chk("R3 byte write ignored", 64'(rd), 64'h4022);
    regWr(12'h028, 32'h0000_0055, 2'd1);
    regRd(12'h028, 2'd2, rd); chk("R3 halfword write ignored", 64'(rd), 64'h4022);
    regRd(12'h028, 2'd1, rd); chk("R3 halfword read zero", 64'(rd), 64'h0);
  endtask

  task automatic testDrop();
    request(5'd2); idle(4);
    chk("R6 unused vector no message", 64'(msgCnt), 64'd0);
    regRd(12'h800, 2'd2, rd); chk("R6 unused vector no pending", 64'(rd), 64'h0);
    useOp(1'b1, 5'd9);
    request(5'd9); idle(4);
    chk("R6 out of range vector dropped", 64'(msgCnt), 64'd0);
  endtask

  task automatic testPendUnmask();
    useOp(1'b1, 5'd2);
    request(5'd2); idle(4);
    chk("R7 masked request no message", 64'(msgCnt), 64'd0);
    regRd(12'h800, 2'd2, rd); chk("R7 masked request pending", 64'(rd), 64'h4);
    regWr(12'h800, 32'h0, 2'd2);
    regRd(12'h800, 2'd2, rd); chk("R4 pending write ignored", 64'(rd), 64'h4);
    regWr(12'h02C, 32'h0, 2'd2); idle(4);
    chk("R9 unmask replays", 64'(msgCnt), 64'd1);
    chk("R9 replay address", logAddr[0], 64'h0000_0001_FEE0_1000);
    chk("R9 replay data", 64'(logData[0]), 64'h4022);
    regRd(12'h800, 2'd2, rd); chk("R9 pending cleared", 64'(rd), 64'h0);
  endtask

  task automatic testStall();
    logic [63:0] a0;
    msgReady = 0;
    request(5'd2);
    chk("R8 message valid next cycle", 64'(msgValid), 64'h1);
    a0 = msgAddr;
    idle(3);
    chk("R8 message held", 64'(msgValid), 64'h1);
    chk("R8 address stable", msgAddr, a0);
    chk("R12 no request accepted while held", 64'(reqReady), 64'h0);
    chk("R12 nothing delivered while stalled", 64'(msgCnt), 64'd1);
    msgReady = 1; idle(3);
    chk("R8 delivered after ready", 64'(msgCnt), 64'd2);
    chk("R8 delivered data", 64'(logData[1]), 64'h4022);
  endtask

  task automatic testSweep();
    cfgWr(1'b1, 1'b1);
    chk("R10 intx deassert pulse", 64'(intxDeassert), 64'h1);
    chk("R5 flags enable and mask", 64'(cfgFlags), 64'hC007);
    request(5'd2); idle(3);
    regWr(12'h050, 32'hFEE0_2000, 2'd2);
    regWr(12'h058, 32'h0000_4055, 2'd2);
    useOp(1'b1, 5'd5);
    regWr(12'h05C, 32'h0, 2'd2);
    request(5'd5); idle(4);
    chk("R7 function mask holds messages", 64'(msgCnt), 64'd2);
    regRd(12'h800, 2'd2, rd); chk("R7 function mask pending", 64'(rd), 64'h24);
    cfgWr(1'b1, 1'b0);
    chk("R10 intx pulse on unmask", 64'(intxDeassert), 64'h1);
    idle(16);
    chk("R10 sweep message count", 64'(msgCnt), 64'd4);
    chk("R10 sweep first vector 2", 64'(logData[2]), 64'h4022);
    chk("R10 sweep second vector 5", 64'(logData[3]), 64'h4055);
    chk("R10 sweep address", logAddr[3], 64'h0000_0000_FEE0_2000);
    regRd(12'h800, 2'd2, rd); chk("R10 sweep pending cleared", 64'(rd), 64'h0);
  endtask

  task automatic testUseCount();
    regWr(12'h05C, 32'h1, 2'd2);
    useOp(1'b1, 5'd5);
    request(5'd5); idle(3);
    regRd(12'h800, 2'd2, rd); chk("R11 pending with count two", 64'(rd), 64'h20);
    useOp(1'b0, 5'd5);
    regRd(12'h800, 2'd2, rd); chk("R11 pending kept at count one", 64'(rd), 64'h20);
    useOp(1'b0, 5'd5);
    regRd(12'h800, 2'd2, rd); chk("R11 pending cleared at zero", 64'(rd), 64'h0);
    useOp(1'b0, 5'd5);
    useOp(1'b1, 5'd5);
    request(5'd5); idle(3);
    regRd(12'h800, 2'd2, rd); chk("R11 decrement at zero ignored", 64'(rd), 64'h20);
    chk("R11 no message while masked", 64'(msgCnt), 64'd4);
  endtask

  task automatic testLateReset();
    @(negedge clk); rstN = 0;
    idle(2); rstN = 1;
    chk("R1 flags cleared by reset", 64'(cfgFlags), 64'h0007);
    regRd(12'h800, 2'd2, rd); chk("R1 pending cleared by reset", 64'(rd), 64'h0);
    regRd(12'h05C, 2'd2, rd); chk("R1 mask set by reset", 64'(rd), 64'h1);
    regRd(12'h050, 2'd2, rd); chk("R1 table zeroed by reset", 64'(rd), 64'h0);
    request(5'd2); idle(4);
    regRd(12'h800, 2'd2, rd); chk("R1 use count cleared by reset", 64'(rd), 64'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCnt++; testCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1;
    @(negedge clk);
    testReset();
    testTable();
    testWidth();
    testDrop();
    testPendUnmask();
    testStall();
    testSweep();
    testUseCount();
    testLateReset();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule